// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Controller

This block is the interrupt logic inside a peripheral interface device. The device's timers, port handshakes and shift register are not part of it: they reach it only as single-cycle event strobes, which latch a pending flag, and as service strobes, which drop a flag when software services that source. Software reaches the block over a byte-wide synchronous register bus. The bus carries a chip select, a 4-bit register select, read and write strobes, and separate 8-bit write and read data buses.

There are seven sources. Each source has a pending flag and an enable bit. Software clears flags by writing ones. The enable register is changed through a mask: bit 7 of the written byte says whether the masked bits are set or cleared. The top bit of the flag register reads back as the summary of pending, enabled sources, so an interrupt handler can test it with a sign-bit branch. The active-low request output is an open request line. Several instances can share one request line through an AND of their outputs.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A write with register select 0x9 (the flag register) clears every flag whose data bit (6..0) is 1. Flags written with 0 are left unchanged, and data bit 7 is ignored, so 0x7F and 0xFF both clear all flags.
- R2: A write with register select 0xA (the enable register) and data bit 7 = 1 sets each enable bit whose data bit (6..0) is 1. For example, 0x82 enables source 1 only.
- R3: A write to the enable register with data bit 7 = 0 clears each enable bit whose data bit is 1. For example, 0x02 disables source 1 and 0x7F disables all sources. In both write forms, enable bits written with 0 are untouched.
- R4: A read of the flag register returns the flags in bits 6..0 (bit i = source i). Bit 7 reads 1 exactly when some flag and its enable bit are both 1.
- R5: A read of the enable register returns bit 7 as 1 and the enables in bits 6..0.
- R6: irq_n is low exactly while at least one source is both flagged and enabled. It is never low while all enables are 0.
- R7: Reset clears all flags and all enables and drives irq_n high. The reset is asserted asynchronously and released on the second rising clock edge after rst_n rises. Register updates resume one edge later.
- R8: A 1 on bit i of svc_clr clears flag i on the next clock edge.
- R9: A 1 on bit i of evt sets flag i on the next clock edge, even when a flag write or a service strobe clears flag i on the same edge: the set wins.
- R10: Flags are set by events whether or not the source is enabled. A disabled flag is visible on a read but does not drive irq_n.
- R11: Register accesses take effect only with cs high. Writes to other select codes change no state, and reads of other select codes, or with cs or rd low, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for register accesses |
| rsel | input | 4 | Register select code |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from select and state |
| evt | input | 7 | Single-cycle event strobes, one per source |
| svc_clr | input | 7 | Service-access clear strobes, one per source |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall on the same edge: a flag is set by its event strobe, and the same flag is cleared, either by a write-one-to-clear access or by a service strobe. The bench pulses the event and the clear for one source together, then reads the flag register. The flag must read as set and, where it is enabled, irq_n must be low. A long stretch of random traffic on two instances then makes these collisions repeatedly. A cycle-by-cycle reference model judges every read value, both request outputs and their ANDed line.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Decoded register-bus access for one cycle
  typedef struct packed {
    logic flag_wr;
    logic ena_wr;
    logic flag_rd;
    logic ena_rd;
  } bus_dec_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shreg <= '0;
    else           shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shreg[STAGES-1];

endmodule

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_pkg::*;
#(
  parameter int              SEL_W    = 4,
  parameter logic [SEL_W-1:0] FLAG_SEL = 4'h9,
  parameter logic [SEL_W-1:0] ENA_SEL  = 4'hA
) (
  input  logic             cs,
  input  logic [SEL_W-1:0] rsel,
  input  logic             rd,
  input  logic             wr,
  output bus_dec_t         dec
);

  logic hit_flag, hit_ena;

  always_comb begin
    hit_flag    = cs && (rsel == FLAG_SEL);
    hit_ena     = cs && (rsel == ENA_SEL);
    dec.flag_wr = hit_flag && wr;
    dec.ena_wr  = hit_ena  && wr;
    dec.flag_rd = hit_flag && rd;
    dec.ena_rd  = hit_ena  && rd;
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr_en,
  input  logic [NSRC-1:0] clr_wr_mask,
  input  logic [NSRC-1:0] svc_clr,
  output logic [NSRC-1:0] flags
);

  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] flags_nxt;
  logic            flags_upd;

  always_comb begin
    clr_mask  = svc_clr | (clr_wr_en ? clr_wr_mask : '0);
    // set applied after clear: a simultaneous event is never lost
    flags_nxt = (flags & ~clr_mask) | evt;
    flags_upd = (|clr_mask) || (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= '0;
    else if (flags_upd) flags <= flags_nxt;
  end

  a_r1_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_en |=> ((flags & $past(clr_wr_mask) & ~$past(evt)) == '0));

  a_r8_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_clr != '0) |=> ((flags & $past(svc_clr) & ~$past(evt)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr_en && svc_clr == '0) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NSRC:0]   wr_data,
  output logic [NSRC-1:0] ena
);

  logic [NSRC-1:0] sel_mask;
  logic [NSRC-1:0] ena_nxt;

  always_comb begin
    sel_mask = wr_data[NSRC-1:0];
    if (wr_data[NSRC]) ena_nxt = ena | sel_mask;
    else               ena_nxt = ena & ~sel_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ena <= '0;
    else if (wr_en) ena <= ena_nxt;
  end

  a_r2_set_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[NSRC]) |=>
      ((ena & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

  a_r3_clear_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[NSRC]) |=> ((ena & $past(wr_data[NSRC-1:0])) == '0));

  a_r3_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((ena ^ $past(ena)) & ~$past(wr_data[NSRC-1:0])) == '0));

  a_r11_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ena));

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int               NSRC     = 7,
  parameter int               SEL_W    = 4,
  parameter logic [SEL_W-1:0] FLAG_SEL = 4'h9,
  parameter logic [SEL_W-1:0] ENA_SEL  = 4'hA,
  localparam int              DW       = NSRC + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic [SEL_W-1:0] rsel,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NSRC-1:0]  evt,
  input  logic [NSRC-1:0]  svc_clr,
  output logic             irq_n
);

  logic            rst_q;
  bus_dec_t        dec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] ena_q;
  logic            pend_any;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  irq_bus_dec #(.SEL_W(SEL_W), .FLAG_SEL(FLAG_SEL), .ENA_SEL(ENA_SEL)) u_dec (
    .cs   (cs),
    .rsel (rsel),
    .rd   (rd),
    .wr   (wr),
    .dec  (dec)
  );

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk         (clk),
    .rst_n       (rst_q),
    .evt         (evt),
    .clr_wr_en   (dec.flag_wr),
    .clr_wr_mask (wdata[NSRC-1:0]),
    .svc_clr     (svc_clr),
    .flags       (flag_q)
  );

  irq_enable_reg #(.NSRC(NSRC)) u_ena (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (dec.ena_wr),
    .wr_data (wdata),
    .ena     (ena_q)
  );

  always_comb begin
    pend_any = |(flag_q & ena_q);
    irq_n    = ~pend_any;
    rdata    = '0;
    if (dec.flag_rd)     rdata = {pend_any, flag_q};
    else if (dec.ena_rd) rdata = {1'b1, ena_q};
  end

  a_r6_needs_permission: assert property (@(posedge clk) disable iff (!rst_q)
    !irq_n |-> (ena_q != '0));

  a_r7_reset_clean: assert property (@(posedge clk)
    $rose(rst_q) |-> (flag_q == '0 && ena_q == '0 && irq_n));

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (!cs || !rd) |-> (rdata == '0));

endmodule

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;

  localparam logic [3:0] FSEL = 4'h9;
  localparam logic [3:0] ESEL = 4'hA;
  localparam logic [3:0] OSEL = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs [2];
  logic [3:0] sel [2];
  logic       rd [2];
  logic       wr [2];
  logic [7:0] wd [2];
  logic [6:0] ev [2];
  logic [6:0] sv [2];
  logic [7:0] rdat [2];
  logic       irqn [2];

  logic [6:0] mf [2];
  logic [6:0] me [2];
  int         rcnt;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  string      phase = "R7 reset";

  always #2 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs[0]), .rsel(sel[0]), .rd(rd[0]), .wr(wr[0]),
    .wdata(wd[0]), .rdata(rdat[0]), .evt(ev[0]), .svc_clr(sv[0]), .irq_n(irqn[0]));

  irq_flag_ctrl i_irq_flag_ctrl_b (
    .clk(clk), .rst_n(rst_n), .cs(cs[1]), .rsel(sel[1]), .rd(rd[1]), .wr(wr[1]),
    .wdata(wd[1]), .rdata(rdat[1]), .evt(ev[1]), .svc_clr(sv[1]), .irq_n(irqn[1]));

  // Reference model: register updates start on the third edge after rst_n rises
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0;
      for (int k = 0; k < 2; k++) begin mf[k] = '0; me[k] = '0; end
    end else begin
      if (rcnt >= 2) begin
        for (int k = 0; k < 2; k++) begin
          logic [6:0] c;
          c = sv[k];
          if (cs[k] && wr[k] && sel[k] == FSEL) c = c | wd[k][6:0];
          mf[k] = (mf[k] & ~c) | ev[k];
          if (cs[k] && wr[k] && sel[k] == ESEL)
            me[k] = wd[k][7] ? (me[k] | wd[k][6:0]) : (me[k] & ~wd[k][6:0]);
        end
      end else begin
        rcnt++;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual 0x%0h expected 0x%0h", phase, what, act, exp);
    end
  endtask

  // Compare on every falling edge, before new inputs are driven
  always @(negedge clk) begin
    if (!done) begin
      bit pend [2];
      for (int k = 0; k < 2; k++) begin
        logic [7:0] er;
        pend[k] = |(mf[k] & me[k]);
        er = 8'h00;
        if (cs[k] && rd[k] && sel[k] == FSEL)      er = {pend[k], mf[k]};
        else if (cs[k] && rd[k] && sel[k] == ESEL) er = {1'b1, me[k]};
        chk(k == 0 ? "rdata A" : "rdata B", int'(rdat[k]), int'(er));
        chk(k == 0 ? "irq_n A" : "irq_n B", int'(irqn[k]), int'(!pend[k]));
      end
      chk("R6 ANDed request line", int'(irqn[0] & irqn[1]), int'(!(pend[0] || pend[1])));
    end
  end

  task automatic idle();
    for (int k = 0; k < 2; k++) begin
      cs[k] = 0; sel[k] = '0; rd[k] = 0; wr[k] = 0; wd[k] = '0; ev[k] = '0; sv[k] = '0;
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr_reg(input int k, input logic [3:0] s, input logic [7:0] d);
    cs[k] = 1; wr[k] = 1; sel[k] = s; wd[k] = d; tick(); idle();
  endtask

  task automatic rd_reg(input int k, input logic [3:0] s);
    cs[k] = 1; rd[k] = 1; sel[k] = s; tick(); idle();
  endtask

  task automatic pulse(input int k, input logic [6:0] e, input logic [6:0] c);
    ev[k] = e; sv[k] = c; tick(); idle();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    repeat (3) tick();
    rst_n = 1;
    phase = "R7 R5 after reset";
    rd_reg(0, ESEL); rd_reg(0, FSEL); rd_reg(0, ESEL); rd_reg(0, FSEL);

    phase = "R10 event while disabled";
    pulse(0, 7'h05, 7'h00); rd_reg(0, FSEL);

    phase = "R2 R4 R6 enable source 2";
    wr_reg(0, ESEL, 8'h84); rd_reg(0, FSEL); rd_reg(0, ESEL);

    phase = "R3 clear enable";
    wr_reg(0, ESEL, 8'h04); rd_reg(0, ESEL); rd_reg(0, FSEL);
    wr_reg(0, ESEL, 8'h82); rd_reg(0, ESEL);
    wr_reg(0, ESEL, 8'h7F); rd_reg(0, ESEL);
    wr_reg(0, ESEL, 8'hFF); rd_reg(0, ESEL);
    wr_reg(0, ESEL, 8'h02); rd_reg(0, ESEL);

    phase = "R1 write-one-to-clear";
    wr_reg(0, FSEL, 8'h01); rd_reg(0, FSEL);
    wr_reg(0, FSEL, 8'h7F); rd_reg(0, FSEL);
    pulse(0, 7'h7F, 7'h00); wr_reg(0, FSEL, 8'hFF); rd_reg(0, FSEL);

    phase = "R8 service clear";
    pulse(0, 7'h10, 7'h00); rd_reg(0, FSEL);
    pulse(0, 7'h00, 7'h10); rd_reg(0, FSEL);

    phase = "R9 set wins over write clear";
    cs[0] = 1; wr[0] = 1; sel[0] = FSEL; wd[0] = 8'h08; ev[0] = 7'h08; tick(); idle();
    rd_reg(0, FSEL);
    phase = "R9 set wins over service clear";
    pulse(0, 7'h20, 7'h20); rd_reg(0, FSEL);

    phase = "R11 ignored accesses";
    wr[0] = 1; sel[0] = FSEL; wd[0] = 8'hFF; tick(); idle(); rd_reg(0, FSEL);
    wr_reg(0, OSEL, 8'hFF); rd_reg(0, FSEL); rd_reg(0, OSEL);
    rd[0] = 1; sel[0] = FSEL; tick(); idle();

    phase = "R6 second instance on shared line";
    wr_reg(0, FSEL, 8'h7F);
    wr_reg(1, ESEL, 8'hC0); pulse(1, 7'h40, 7'h00); rd_reg(1, FSEL);
    pulse(1, 7'h00, 7'h40); rd_reg(1, FSEL);

    phase = "R9 R1 R2 R3 R8 mixed random traffic";
    for (int n = 0; n < 1500; n++) begin
      for (int k = 0; k < 2; k++) begin
        int s;
        s      = $urandom_range(0, 2);
        cs[k]  = $urandom_range(0, 3) != 0;
        sel[k] = (s == 0) ? FSEL : (s == 1) ? ESEL : OSEL;
        rd[k]  = $urandom_range(0, 1);
        wr[k]  = $urandom_range(0, 2) == 0;
        wd[k]  = 8'($urandom);
        ev[k]  = 7'($urandom & $urandom & $urandom);
        sv[k]  = 7'($urandom & $urandom & $urandom);
      end
      tick();
    end
    idle(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule